// File: doc/BRIEF.md
# Masked Ternary Lookup Table

This block is a content-addressable lookup table. It holds a number of entries, each made of a search key of fixed width, an associated data word (for example an output port number) and a valid flag. Software-side logic fills the table by address and can read any entry back by address.

A lookup presents an argument and a mask together. An entry matches when it is valid and agrees with the argument on every bit position the mask enables. Positions the mask disables are treated as don't-care for every entry alike. The block returns a vector with one match bit per entry. From that vector it also returns the lowest-numbered matching entry, that entry's associated data, and hit and miss flags. All lookup results are registered and appear one clock after the request.

Writes, reads and lookups may all be issued in the same cycle. A lookup always sees the table as it stood before any write issued in that cycle.

Top module: `tcam_lookup`

## Requirements
- R1: After reset every valid flag is clear, `cmp_done`, `cmp_hit` and `cmp_match` are zero, and every lookup misses until an entry is written valid.
- R2: A read issued with `rd_en` returns the stored key, associated data and valid flag of entry `rd_addr` on `rd_key`, `rd_data` and `rd_valid` one cycle later, with `rd_done` high in that cycle.
- R3: For a lookup, bit i of `cmp_match` is 1 exactly when entry i is valid and `((key_i ^ cmp_arg) & cmp_mask) == 0`.
- R4: A lookup with an all-zero mask matches every valid entry, whatever the argument.
- R5: An entry whose valid flag is clear never matches, whatever its stored key, argument or mask.
- R6: On a hit, `cmp_idx` is the lowest-numbered set bit of `cmp_match` and `cmp_data` is the associated data of that entry.
- R7: `cmp_miss` is 1 exactly when `cmp_match` is all zero after a lookup, and `cmp_hit` is its complement. `cmp_idx` and `cmp_data` carry meaning only on a hit.
- R8: Lookup results appear one cycle after `cmp_en` with a one-cycle `cmp_done` pulse. Without `cmp_en`, all lookup outputs hold their last values.
- R9: A write issued in the same cycle as a lookup does not affect that lookup, and it is seen by every lookup from the next cycle on.
- R10: A write with `wr_valid` low removes the entry, so it no longer matches any lookup.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| wr_en | input | 1 | Write entry `wr_addr` |
| wr_addr | input | AW | Entry index to write |
| wr_key | input | WIDTH | Key to store |
| wr_data | input | DATA_W | Associated data to store |
| wr_valid | input | 1 | Valid flag to store |
| rd_en | input | 1 | Read entry `rd_addr` |
| rd_addr | input | AW | Entry index to read |
| rd_done | output | 1 | Read result valid |
| rd_key | output | WIDTH | Key read back |
| rd_data | output | DATA_W | Associated data read back |
| rd_valid | output | 1 | Valid flag read back |
| cmp_en | input | 1 | Start a lookup |
| cmp_arg | input | WIDTH | Lookup argument |
| cmp_mask | input | WIDTH | Lookup mask, 1 = bit is compared |
| cmp_done | output | 1 | Lookup result pulse |
| cmp_match | output | ENTRIES | One match bit per entry |
| cmp_hit | output | 1 | At least one entry matched |
| cmp_miss | output | 1 | No entry matched |
| cmp_idx | output | AW | Lowest matching entry |
| cmp_data | output | DATA_W | Associated data of `cmp_idx` |

## Verification
The hardest case to reach is a lookup whose answer depends on arbitration among several matches while other entries are present but invalid. The table is loaded with duplicate keys, with a removed entry and with an entry never written. Then every argument value is swept under masks that range from all-zero to full width, so many-way ties, single hits and misses all occur. A write and a lookup are also issued in the same cycle on the entry that would win, to show the old contents answer first.

// File: rtl/tcam_pkg.sv
package tcam_pkg;
  function automatic int idx_bits(input int n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction
endpackage

// File: rtl/tcam_store.sv
module tcam_store #(
  parameter int ENTRIES = 16,
  parameter int WIDTH   = 8,
  parameter int DATA_W  = 4,
  localparam int AW     = tcam_pkg::idx_bits(ENTRIES)
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        wr_en,
  input  logic [AW-1:0]               wr_addr,
  input  logic [WIDTH-1:0]            wr_key,
  input  logic [DATA_W-1:0]           wr_data,
  input  logic                        wr_valid,
  output logic [ENTRIES*WIDTH-1:0]    key_flat,
  output logic [ENTRIES*DATA_W-1:0]   data_flat,
  output logic [ENTRIES-1:0]          valid_vec
);
  for (genvar i = 0; i < ENTRIES; i++) begin : g_ent
    logic              sel;
    logic [WIDTH-1:0]  key_q;
    logic [DATA_W-1:0] dat_q;
    logic              val_q;

    assign sel = wr_en && (wr_addr == AW'(i));

    always_ff @(posedge clk) begin
      if (sel) begin
        key_q <= wr_key;
        dat_q <= wr_data;
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   val_q <= 1'b0;
      else if (sel) val_q <= wr_valid;
    end

    assign key_flat[i*WIDTH +: WIDTH]    = key_q;
    assign data_flat[i*DATA_W +: DATA_W] = dat_q;
    assign valid_vec[i]                  = val_q;
  end
endmodule

// File: rtl/tcam_match.sv
module tcam_match #(
  parameter int ENTRIES = 16,
  parameter int WIDTH   = 8
) (
  input  logic [ENTRIES*WIDTH-1:0] key_flat,
  input  logic [ENTRIES-1:0]       valid_vec,
  input  logic [WIDTH-1:0]         arg,
  input  logic [WIDTH-1:0]         mask,
  output logic [ENTRIES-1:0]       match_vec
);
  for (genvar i = 0; i < ENTRIES; i++) begin : g_cmp
    logic [WIDTH-1:0] diff;
    assign diff         = (key_flat[i*WIDTH +: WIDTH] ^ arg) & mask;
    assign match_vec[i] = valid_vec[i] && (diff == '0);
  end
endmodule

// File: rtl/tcam_prio.sv
module tcam_prio #(
  parameter int ENTRIES = 16,
  localparam int AW     = tcam_pkg::idx_bits(ENTRIES)
) (
  input  logic [ENTRIES-1:0] vec,
  output logic               any,
  output logic [AW-1:0]      idx
);
  always_comb begin
    idx = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (vec[i]) idx = AW'(i);
    end
    any = |vec;
  end
endmodule

// File: rtl/tcam_lookup.sv
module tcam_lookup #(
  parameter int ENTRIES = 16,
  parameter int WIDTH   = 8,
  parameter int DATA_W  = 4,
  localparam int AW     = tcam_pkg::idx_bits(ENTRIES)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic [AW-1:0]      wr_addr,
  input  logic [WIDTH-1:0]   wr_key,
  input  logic [DATA_W-1:0]  wr_data,
  input  logic               wr_valid,
  input  logic               rd_en,
  input  logic [AW-1:0]      rd_addr,
  output logic               rd_done,
  output logic [WIDTH-1:0]   rd_key,
  output logic [DATA_W-1:0]  rd_data,
  output logic               rd_valid,
  input  logic               cmp_en,
  input  logic [WIDTH-1:0]   cmp_arg,
  input  logic [WIDTH-1:0]   cmp_mask,
  output logic               cmp_done,
  output logic [ENTRIES-1:0] cmp_match,
  output logic               cmp_hit,
  output logic               cmp_miss,
  output logic [AW-1:0]      cmp_idx,
  output logic [DATA_W-1:0]  cmp_data
);
  // reset: asserted asynchronously, released on a clock edge
  logic rst_meta, rst_sync_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta   <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta   <= 1'b1;
      rst_sync_n <= rst_meta;
    end
  end

  logic [ENTRIES*WIDTH-1:0]  key_flat;
  logic [ENTRIES*DATA_W-1:0] data_flat;
  logic [ENTRIES-1:0]        valid_vec;
  logic [ENTRIES-1:0]        match_c;
  logic                      any_c;
  logic [AW-1:0]             idx_c;

  tcam_store #(.ENTRIES(ENTRIES), .WIDTH(WIDTH), .DATA_W(DATA_W)) u_store (
    .clk(clk), .rst_n(rst_sync_n),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_key(wr_key),
    .wr_data(wr_data), .wr_valid(wr_valid),
    .key_flat(key_flat), .data_flat(data_flat), .valid_vec(valid_vec)
  );

  tcam_match #(.ENTRIES(ENTRIES), .WIDTH(WIDTH)) u_match (
    .key_flat(key_flat), .valid_vec(valid_vec),
    .arg(cmp_arg), .mask(cmp_mask), .match_vec(match_c)
  );

  tcam_prio #(.ENTRIES(ENTRIES)) u_prio (
    .vec(match_c), .any(any_c), .idx(idx_c)
  );

  // next-state
  logic               cdone_d, chit_d, cmiss_d, rdone_d, rval_d;
  logic [ENTRIES-1:0] cmatch_d;
  logic [AW-1:0]      cidx_d;
  logic [DATA_W-1:0]  cdata_d, rdata_d;
  logic [WIDTH-1:0]   rkey_d;

  always_comb begin
    cdone_d  = cmp_en;
    cmatch_d = cmp_match;
    chit_d   = cmp_hit;
    cmiss_d  = cmp_miss;
    cidx_d   = cmp_idx;
    cdata_d  = cmp_data;
    if (cmp_en) begin
      cmatch_d = match_c;
      chit_d   = any_c;
      cmiss_d  = !any_c;
      cidx_d   = idx_c;
      cdata_d  = data_flat[int'(idx_c)*DATA_W +: DATA_W];
    end
    rdone_d = rd_en;
    rkey_d  = rd_key;
    rdata_d = rd_data;
    rval_d  = rd_valid;
    if (rd_en) begin
      rkey_d  = key_flat[int'(rd_addr)*WIDTH +: WIDTH];
      rdata_d = data_flat[int'(rd_addr)*DATA_W +: DATA_W];
      rval_d  = valid_vec[rd_addr];
    end
  end

  // registers
  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      cmp_done  <= 1'b0;
      cmp_match <= '0;
      cmp_hit   <= 1'b0;
      cmp_miss  <= 1'b0;
      cmp_idx   <= '0;
      cmp_data  <= '0;
      rd_done   <= 1'b0;
      rd_key    <= '0;
      rd_data   <= '0;
      rd_valid  <= 1'b0;
    end else begin
      cmp_done  <= cdone_d;
      cmp_match <= cmatch_d;
      cmp_hit   <= chit_d;
      cmp_miss  <= cmiss_d;
      cmp_idx   <= cidx_d;
      cmp_data  <= cdata_d;
      rd_done   <= rdone_d;
      rd_key    <= rkey_d;
      rd_data   <= rdata_d;
      rd_valid  <= rval_d;
    end
  end
endmodule

// File: rtl/tcam_lookup_chk.sv
module tcam_lookup_chk #(
  parameter int ENTRIES = 16,
  localparam int AW     = tcam_pkg::idx_bits(ENTRIES)
) (
  input logic               clk,
  input logic               rst_n,
  input logic               rd_en,
  input logic               rd_done,
  input logic               cmp_en,
  input logic               cmp_done,
  input logic [ENTRIES-1:0] cmp_match,
  input logic               cmp_hit,
  input logic               cmp_miss,
  input logic [AW-1:0]      cmp_idx
);
  localparam logic [ENTRIES-1:0] ONE = 1;

  a_r8_done_next: assert property (@(posedge clk) disable iff (!rst_n)
    cmp_en |=> cmp_done);
  a_r8_done_only: assert property (@(posedge clk) disable iff (!rst_n)
    !cmp_en |=> !cmp_done);
  a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !cmp_en |=> ($stable(cmp_match) && $stable(cmp_hit) && $stable(cmp_idx)));
  a_r7_hit_xor_miss: assert property (@(posedge clk) disable iff (!rst_n)
    cmp_done |-> (cmp_hit != cmp_miss));
  a_r7_miss_empty: assert property (@(posedge clk) disable iff (!rst_n)
    (cmp_done && cmp_miss) |-> (cmp_match == '0));
  a_r6_idx_set: assert property (@(posedge clk) disable iff (!rst_n)
    (cmp_done && cmp_hit) |-> cmp_match[cmp_idx]);
  a_r6_idx_lowest: assert property (@(posedge clk) disable iff (!rst_n)
    (cmp_done && cmp_hit) |-> ((cmp_match & ((ONE << cmp_idx) - ONE)) == '0));
  a_r2_read_next: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |=> rd_done);
endmodule

bind tcam_lookup tcam_lookup_chk #(.ENTRIES(ENTRIES)) u_chk (
  .clk(clk), .rst_n(rst_sync_n), .rd_en(rd_en), .rd_done(rd_done),
  .cmp_en(cmp_en), .cmp_done(cmp_done), .cmp_match(cmp_match),
  .cmp_hit(cmp_hit), .cmp_miss(cmp_miss), .cmp_idx(cmp_idx)
);

// File: tb/sim_tcam_lookup.sv
`timescale 1ns/1ps
module sim_tcam_lookup;
  localparam int N  = 8;
  localparam int W  = 6;
  localparam int D  = 4;
  localparam int AW = 3;

  logic clk = 1'b0;
  logic rst_n;
  logic wr_en, wr_valid, rd_en, cmp_en;
  logic [AW-1:0] wr_addr, rd_addr;
  logic [W-1:0]  wr_key, cmp_arg, cmp_mask;
  logic [D-1:0]  wr_data;
  logic rd_done, rd_valid, cmp_done, cmp_hit, cmp_miss;
  logic [W-1:0] rd_key;
  logic [D-1:0] rd_data, cmp_data;
  logic [N-1:0] cmp_match;
  logic [AW-1:0] cmp_idx;

  always #4 clk = ~clk;

  tcam_lookup #(.ENTRIES(N), .WIDTH(W), .DATA_W(D)) u0 (
    .clk(clk), .rst_n(rst_n),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_key(wr_key), .wr_data(wr_data), .wr_valid(wr_valid),
    .rd_en(rd_en), .rd_addr(rd_addr), .rd_done(rd_done), .rd_key(rd_key), .rd_data(rd_data),
    .rd_valid(rd_valid),
    .cmp_en(cmp_en), .cmp_arg(cmp_arg), .cmp_mask(cmp_mask), .cmp_done(cmp_done),
    .cmp_match(cmp_match), .cmp_hit(cmp_hit), .cmp_miss(cmp_miss), .cmp_idx(cmp_idx),
    .cmp_data(cmp_data)
  );

  int checks = 0;
  int errors = 0;
  logic [W-1:0] m_key [N];
  logic [D-1:0] m_dat [N];
  logic         m_val [N];

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic wr(input int a, input logic [W-1:0] k, input logic [D-1:0] d, input logic v);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = AW'(a); wr_key = k; wr_data = d; wr_valid = v;
    @(negedge clk);
    wr_en = 1'b0;
    m_key[a] = k; m_dat[a] = d; m_val[a] = v;
  endtask

  task automatic rd_chk(input int a);
    @(negedge clk);
    rd_en = 1'b1; rd_addr = AW'(a);
    @(negedge clk);
    rd_en = 1'b0;
    chk(rd_done == 1'b1, "R2", "rd_done", 32'(rd_done), 1);
    chk(rd_valid == m_val[a], "R2", "rd_valid", 32'(rd_valid), 32'(m_val[a]));
    if (m_val[a]) begin
      chk(rd_key == m_key[a], "R2", "rd_key", 32'(rd_key), 32'(m_key[a]));
      chk(rd_data == m_dat[a], "R2", "rd_data", 32'(rd_data), 32'(m_dat[a]));
    end
  endtask

  function automatic logic [N-1:0] exp_vec(input logic [W-1:0] a, input logic [W-1:0] m);
    logic [N-1:0] v = '0;
    for (int i = 0; i < N; i++)
      v[i] = m_val[i] && (((m_key[i] ^ a) & m) == '0);
    return v;
  endfunction

  // result check against the model; R3/R5 vector, R6 encode, R7 flags
  task automatic check_result(input logic [N-1:0] ev, input string req);
    int lo = -1;
    for (int i = N - 1; i >= 0; i--) if (ev[i]) lo = i;
    chk(cmp_done == 1'b1, "R8", "cmp_done", 32'(cmp_done), 1);
    chk(cmp_match == ev, req, "cmp_match", 32'(cmp_match), 32'(ev));
    chk(cmp_miss == (ev == '0), "R7", "cmp_miss", 32'(cmp_miss), 32'(ev == '0));
    chk(cmp_hit == (ev != '0), "R7", "cmp_hit", 32'(cmp_hit), 32'(ev != '0));
    if (lo >= 0) begin
      chk(cmp_idx == AW'(lo), "R6", "cmp_idx", 32'(cmp_idx), 32'(lo));
      chk(cmp_data == m_dat[lo], "R6", "cmp_data", 32'(cmp_data), 32'(m_dat[lo]));
    end
  endtask

  task automatic cmp_chk(input logic [W-1:0] a, input logic [W-1:0] m, input string req);
    logic [N-1:0] ev;
    @(negedge clk);
    cmp_en = 1'b1; cmp_arg = a; cmp_mask = m;
    ev = exp_vec(a, m);
    @(negedge clk);
    cmp_en = 1'b0;
    check_result(ev, req);
  endtask

  initial begin : watchdog
    #1000000;
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin : stim
    logic [W-1:0] masks [6];
    logic [N-1:0] ev;
    logic [N-1:0] held_m;
    logic [AW-1:0] held_i;
    masks[0] = 6'h00; masks[1] = 6'h3F; masks[2] = 6'h0F;
    masks[3] = 6'h30; masks[4] = 6'h2A; masks[5] = 6'h3E;
    for (int i = 0; i < N; i++) begin m_val[i] = 1'b0; m_key[i] = '0; m_dat[i] = '0; end
    rst_n = 1'b0; wr_en = 0; rd_en = 0; cmp_en = 0;
    wr_addr = '0; wr_key = '0; wr_data = '0; wr_valid = 0;
    rd_addr = '0; cmp_arg = '0; cmp_mask = '0;
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(cmp_done == 0 && cmp_hit == 0 && cmp_match == '0, "R1", "outputs in reset",
        {cmp_done, cmp_hit, 30'(cmp_match)}, 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk(cmp_done == 0 && cmp_match == '0, "R1", "outputs after reset",
        {cmp_done, 31'(cmp_match)}, 0);
    cmp_chk(6'h15, 6'h00, "R1");
    chk(cmp_miss == 1'b1, "R1", "empty table misses", 32'(cmp_miss), 1);

    // load: entry 6 duplicates entry 2, entry 3 removed, entry 7 never written
    for (int i = 0; i < 7; i++) wr(i, W'((i * 13 + 5) & 63), D'(i ^ 10), 1'b1);
    wr(6, m_key[2], 4'hF, 1'b1);
    wr(3, m_key[3], m_dat[3], 1'b0);
    for (int i = 0; i < N; i++) rd_chk(i);

    // R4: zero mask matches all valid entries
    cmp_chk(6'h2D, 6'h00, "R4");
    chk(cmp_match == 8'b0111_0111, "R4", "zero mask vector", 32'(cmp_match), 32'h77);
    // R5: removed entry 3 never matches even on exact key
    cmp_chk(m_key[3], 6'h3F, "R5");
    chk(cmp_match[3] == 1'b0, "R5", "invalid entry bit", 32'(cmp_match[3]), 0);
    // R6: duplicate keys, lowest index wins
    cmp_chk(m_key[2], 6'h3F, "R6");
    chk(cmp_idx == 3'd2 && cmp_data == m_dat[2], "R6", "tie to entry 2",
        {cmp_idx, 1'b0, cmp_data}, {3'd2, 1'b0, m_dat[2]});

    // R3: sweep all arguments under several masks
    for (int mi = 0; mi < 6; mi++)
      for (int a = 0; a < 64; a++)
        cmp_chk(W'(a), masks[mi], "R3");

    // R8: outputs hold while idle
    cmp_chk(m_key[1], 6'h3F, "R8");
    held_m = cmp_match; held_i = cmp_idx;
    repeat (3) @(negedge clk);
    chk(cmp_done == 1'b0, "R8", "done drops", 32'(cmp_done), 0);
    chk(cmp_match == held_m && cmp_idx == held_i, "R8", "held result",
        {cmp_idx, 1'b0, cmp_match}, {held_i, 1'b0, held_m});

    // R9: write and lookup in the same cycle on entry 0
    @(negedge clk);
    ev = exp_vec(6'h3C, 6'h3F);
    wr_en = 1; wr_addr = 0; wr_key = 6'h3C; wr_data = 4'h1; wr_valid = 1;
    cmp_en = 1; cmp_arg = 6'h3C; cmp_mask = 6'h3F;
    @(negedge clk);
    wr_en = 0; cmp_en = 0;
    m_key[0] = 6'h3C; m_dat[0] = 4'h1; m_val[0] = 1;
    check_result(ev, "R9");
    chk(cmp_match[0] == 1'b0, "R9", "old contents answer", 32'(cmp_match[0]), 0);
    cmp_chk(6'h3C, 6'h3F, "R9");
    chk(cmp_idx == 0 && cmp_hit, "R9", "new contents seen", {cmp_hit, 3'(cmp_idx)}, 32'h8);

    // R10: removing entry 0 stops it matching
    wr(0, 6'h3C, 4'h1, 1'b0);
    cmp_chk(6'h3C, 6'h3F, "R10");
    chk(cmp_match[0] == 1'b0, "R10", "removed entry", 32'(cmp_match[0]), 0);
    rd_chk(0);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule